// File: doc/BRIEF.md
# Mailbox Transmit-Complete Interrupt Flags

This block holds one sticky interrupt flag for each of the 31 mailboxes of a message controller. It also drives a single level-sensitive transmit interrupt line. A mailbox's flag is captured only when that mailbox reports a finished transmission in a cycle where its interrupt enable bit is 1. The interrupt enable therefore decides whether an event is recorded at all; it does not gate an output. Software clears flags by writing ones. A separate acknowledge vector records every finished transmission regardless of the enable, so software can poll completions without taking interrupts.

The direction input qualifies the flags on the way out. A mailbox configured for receive shows a zero in the flag word and does not contribute to the interrupt line. The interrupt line is the registered OR of the direction-qualified flags. Both the flag word and the acknowledge word are read through a small word-addressed register port that has a one-cycle write strobe and combinational read data.

Top module: `mbx_txirq_flags`

## Requirements
- R1: While `rst` is high at a clock edge, all flag bits, all acknowledge bits and `tx_irq_o` become 0.
- R2: A `tx_done_i[x]` pulse in a cycle where `irq_en_i[x]` is 1 sets flag x at that clock edge. The flag is visible in bit x of the flag word (word index 0) from then on.
- R3: A `tx_done_i[x]` pulse while `irq_en_i[x]` is 0 leaves flag x at 0, and `tx_irq_o` stays low because of that event.
- R4: A write to word index 0 clears every flag whose write-data bit is 1. Bits written 0 keep their value.
- R5: When a capture and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R6: `tx_irq_o` equals, one clock later, the OR of all flags whose mailbox is configured for transmit (`is_tx_i[x]`=1).
- R7: A mailbox with `is_tx_i[x]`=0 reads 0 in bit x of the flag word and does not raise `tx_irq_o`. Its stored flag reappears when the mailbox returns to transmit.
- R8: Bit 31 of every read word is 0, whatever was written to it.
- R9: Every `tx_done_i[x]` pulse sets bit x of the acknowledge word (word index 1), whatever `irq_en_i[x]` holds. A write to word index 1 clears the bits written 1, and a simultaneous pulse wins over the clear.
- R10: Clearing `irq_en_i[x]` after flag x is set does not clear the flag.
- R11: Word indices 2 and 3 read 0, and writes to them change neither the flags nor the acknowledge word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done_i | input | 31 | One-cycle transmit-finished pulse per mailbox |
| irq_en_i | input | 31 | Per-mailbox interrupt enable (gates capture) |
| is_tx_i | input | 31 | Per-mailbox direction, 1 = transmit, 0 = receive |
| reg_wr_i | input | 1 | Single-cycle register write strobe |
| reg_addr_i | input | 2 | Word index: 0 flags, 1 acknowledge, 2..3 unmapped |
| reg_wdata_i | input | 32 | Write data, ones clear the matching bits |
| reg_rdata_o | output | 32 | Combinational read data of the addressed word |
| tx_irq_o | output | 1 | Registered transmit interrupt, high while any qualified flag is set |

## Verification
A wrong stored flag shows at the ports in one of two places. It appears in the flag word on the same cycle the read address selects it. It appears on the interrupt line exactly one clock after the flag changes, provided the mailbox is in transmit mode. A flag held for a receive mailbox is hidden at both ports, so the bench switches the direction back and checks that the stored value reappears. The bench compares the read word and the interrupt line with a behavioural model on every cycle, so a lost set, a lost clear or a wrong priority is seen no later than the next sampling point.

// File: rtl/txf_pkg.sv
package txf_pkg;

  // Register word selected by the port address.
  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_ACK  = 2'd1,
    SEL_NONE = 2'd2
  } txf_sel_e;

endpackage

// File: rtl/txf_w1c_bank.sv
// Bank of sticky bits: a set input raises a bit, a clear input lowers it,
// and set has priority so no event is dropped.
module txf_w1c_bank #(
  parameter int WIDTH = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        q_o[b] <= 1'b0;
      end else if (set_i[b]) begin
        q_o[b] <= 1'b1;
      end else if (clr_i[b]) begin
        q_o[b] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/txf_irq_gen.sv
// Registered OR of direction-qualified flags.
module txf_irq_gen #(
  parameter int WIDTH = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] flag_i,
  input  logic [WIDTH-1:0] qual_i,
  output logic             irq_o
);

  logic [WIDTH-1:0] eff;
  assign eff = flag_i & qual_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
    end else begin
      irq_o <= |eff;
    end
  end

endmodule

// File: rtl/txf_read_mux.sv
// Selects the addressed word and pads the reserved upper bits with zero.
module txf_read_mux
  import txf_pkg::*;
#(
  parameter int NUM_MBX = 31,
  parameter int DATA_W  = 32
) (
  input  txf_sel_e            sel_i,
  input  logic [NUM_MBX-1:0]  flag_i,
  input  logic [NUM_MBX-1:0]  qual_i,
  input  logic [NUM_MBX-1:0]  ack_i,
  output logic [DATA_W-1:0]   rdata_o
);

  localparam int PAD_W = DATA_W - NUM_MBX;

  logic [NUM_MBX-1:0] word;

  always_comb begin
    unique case (sel_i)
      SEL_FLAG: word = flag_i & qual_i;
      SEL_ACK:  word = ack_i;
      default:  word = '0;
    endcase
  end

  if (PAD_W > 0) begin : g_pad
    assign rdata_o = {{PAD_W{1'b0}}, word};
  end else begin : g_nopad
    assign rdata_o = word[DATA_W-1:0];
  end

endmodule

// File: rtl/mbx_txirq_flags.sv
module mbx_txirq_flags
  import txf_pkg::*;
#(
  parameter int NUM_MBX   = 31,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int FLAG_ADDR = 0,
  parameter int ACK_ADDR  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_MBX-1:0] tx_done_i,
  input  logic [NUM_MBX-1:0] irq_en_i,
  input  logic [NUM_MBX-1:0] is_tx_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               tx_irq_o
);

  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(ACK_ADDR);

  txf_sel_e           sel;
  logic [NUM_MBX-1:0] flag_set, flag_clr, ack_clr;
  logic [NUM_MBX-1:0] flag_q, ack_q;

  always_comb begin
    if (reg_addr_i == FLAG_A)     sel = SEL_FLAG;
    else if (reg_addr_i == ACK_A) sel = SEL_ACK;
    else                          sel = SEL_NONE;
  end

  assign flag_set = tx_done_i & irq_en_i;
  assign flag_clr = (reg_wr_i && sel == SEL_FLAG) ? reg_wdata_i[NUM_MBX-1:0] : '0;
  assign ack_clr  = (reg_wr_i && sel == SEL_ACK)  ? reg_wdata_i[NUM_MBX-1:0] : '0;

  txf_w1c_bank #(.WIDTH(NUM_MBX)) u_flag_bank (
    .clk   (clk),
    .rst   (rst),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (flag_q)
  );

  txf_w1c_bank #(.WIDTH(NUM_MBX)) u_ack_bank (
    .clk   (clk),
    .rst   (rst),
    .set_i (tx_done_i),
    .clr_i (ack_clr),
    .q_o   (ack_q)
  );

  txf_irq_gen #(.WIDTH(NUM_MBX)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .flag_i (flag_q),
    .qual_i (is_tx_i),
    .irq_o  (tx_irq_o)
  );

  txf_read_mux #(.NUM_MBX(NUM_MBX), .DATA_W(DATA_W)) u_rd (
    .sel_i   (sel),
    .flag_i  (flag_q),
    .qual_i  (is_tx_i),
    .ack_i   (ack_q),
    .rdata_o (reg_rdata_o)
  );

endmodule

// File: rtl/mbx_txirq_flags_chk.sv
module mbx_txirq_flags_chk #(
  parameter int NUM_MBX   = 31,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int FLAG_ADDR = 0,
  parameter int ACK_ADDR  = 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_MBX-1:0] tx_done_i,
  input logic [NUM_MBX-1:0] irq_en_i,
  input logic [NUM_MBX-1:0] is_tx_i,
  input logic               reg_wr_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic               tx_irq_o,
  input logic [NUM_MBX-1:0] flag_q,
  input logic [NUM_MBX-1:0] ack_q
);

  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

  AST_RST_IRQ_LOW: assert property (@(posedge clk) rst |=> !tx_irq_o); // R1

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (tx_irq_o == $past(|(flag_q & is_tx_i)))); // R6

  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata_o[DATA_W-1]); // R8

  for (genvar i = 0; i < NUM_MBX; i++) begin : g_bit
    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      (tx_done_i[i] && irq_en_i[i]) |=> flag_q[i]); // R2

    AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (rst)
      (!flag_q[i] && !(tx_done_i[i] && irq_en_i[i])) |=> !flag_q[i]); // R3

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !(reg_wr_i && reg_addr_i == FLAG_A && reg_wdata_i[i])) |=> flag_q[i]); // R4

    AST_RX_HIDDEN: assert property (@(posedge clk) disable iff (rst)
      (reg_addr_i == FLAG_A && !is_tx_i[i]) |-> !reg_rdata_o[i]); // R7

    AST_ACK_RECORD: assert property (@(posedge clk) disable iff (rst)
      tx_done_i[i] |=> ack_q[i]); // R9
  end

endmodule

bind mbx_txirq_flags mbx_txirq_flags_chk #(
  .NUM_MBX(NUM_MBX), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .FLAG_ADDR(FLAG_ADDR), .ACK_ADDR(ACK_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .tx_done_i(tx_done_i), .irq_en_i(irq_en_i),
  .is_tx_i(is_tx_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .tx_irq_o(tx_irq_o),
  .flag_q(flag_q), .ack_q(ack_q)
);

// File: tb/mbx_txirq_flags_tb.sv
module mbx_txirq_flags_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 31;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  tx_done = '0, irq_en = '0, is_tx = '0;
  logic          wr = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    started = 0;

  // behavioural reference state
  bit m_flag[N];
  bit m_ack[N];
  bit m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_txirq_flags u_dut (
    .clk(clk), .rst(rst), .tx_done_i(tx_done), .irq_en_i(irq_en),
    .is_tx_i(is_tx), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .tx_irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model update
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_flag[i] = 0; m_ack[i] = 0; end
      m_irq = 0;
    end else begin
      int any;
      any = 0;
      for (int i = 0; i < N; i++) if (m_flag[i] && is_tx[i]) any = 1;
      m_irq = (any != 0);
      for (int i = 0; i < N; i++) begin
        if (tx_done[i] && irq_en[i]) m_flag[i] = 1;
        else if (wr && addr == 2'd0 && wdata[i]) m_flag[i] = 0;
        if (tx_done[i]) m_ack[i] = 1;
        else if (wr && addr == 2'd1 && wdata[i]) m_ack[i] = 0;
      end
    end
  end

  function automatic logic [31:0] exp_read();
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < N; i++) begin
      if (addr == 2'd0) v[i] = m_flag[i] && is_tx[i];
      else if (addr == 2'd1) v[i] = m_ack[i];
    end
    return v;
  endfunction

  // compare on every falling edge
  always @(negedge clk) begin
    if (started) begin
      check(cur_req, rdata, exp_read());
      check({cur_req, "/R6"}, {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse(logic [N-1:0] d);
    tx_done = d; tick(); tx_done = '0;
  endtask

  task automatic wr_word(logic [1:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1; tick(); wr = 1'b0; wdata = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    tick(3);
    @(negedge clk);
    check("R1", rdata, 32'd0);
    check("R1", {31'd0, irq}, 32'd0);
    @(posedge clk); #1;
    rst = 1'b0;
    is_tx = '1; irq_en = '1;
    tick(2);

    // R2: capture under enable
    cur_req = "R2";
    pulse(31'h0000_00A5); tick(2);
    pulse(31'h4000_0001); tick(2);

    // R3: masked mailboxes do not capture
    cur_req = "R3";
    wr_word(2'd0, 32'hFFFF_FFFF); tick(2);
    irq_en = 31'h0000_FFFF;
    pulse(31'h7FFF_0000); tick(3);
    @(negedge clk); check("R3", {31'd0, irq}, 32'd0);
    addr = 2'd1; tick(1); addr = 2'd0;
    irq_en = '1;

    // R4: write-one clear, write-zero keep
    cur_req = "R4";
    pulse(31'h0F0F_0F0F); tick(2);
    wr_word(2'd0, 32'h0000_0F00); tick(2);
    wr_word(2'd0, 32'h0000_0000); tick(2);

    // R5: capture beats clear in the same cycle
    cur_req = "R5";
    addr = 2'd0; wdata = 32'h0000_000F; wr = 1'b1; tx_done = 31'h0000_0005;
    tick(); wr = 1'b0; tx_done = '0; wdata = '0; tick(2);
    @(negedge clk); check("R5", rdata & 32'hF, 32'h5);

    // R7: receive mailboxes hidden, stored flag returns
    cur_req = "R7";
    wr_word(2'd0, 32'h7FFF_FFFF); pulse(31'h0000_0100); tick(2);
    is_tx = ~31'h0000_0100; tick(3);
    @(negedge clk); check("R7", {31'd0, irq}, 32'd0);
    is_tx = '1; tick(3);
    @(negedge clk); check("R7", rdata, 32'h0000_0100);

    // R8: top bit always zero
    cur_req = "R8";
    wr_word(2'd0, 32'h8000_0000); tick(1);
    @(negedge clk); check("R8", {31'd0, rdata[31]}, 32'd0);

    // R9: acknowledge word regardless of enable, set beats clear
    cur_req = "R9";
    addr = 2'd1; irq_en = '0;
    pulse(31'h0030_0000); tick(2);
    wdata = 32'h0030_0000; wr = 1'b1; tx_done = 31'h0010_0000;
    tick(); wr = 1'b0; tx_done = '0; wdata = '0; tick(1);
    @(negedge clk); check("R9", rdata & 32'h0030_0000, 32'h0010_0000);
    wr_word(2'd1, 32'h7FFF_FFFF); addr = 2'd0; irq_en = '1;

    // R10: dropping the enable keeps the flag
    cur_req = "R10";
    pulse(31'h0000_2000); irq_en = '0; tick(3);
    @(negedge clk); check("R10", rdata & 32'h2000, 32'h2000);
    irq_en = '1;

    // R11: unmapped words
    cur_req = "R11";
    wr_word(2'd2, 32'hFFFF_FFFF); wr_word(2'd3, 32'hFFFF_FFFF); addr = 2'd3; tick(1);
    @(negedge clk); check("R11", rdata, 32'd0);
    addr = 2'd0; tick(1);
    @(negedge clk); check("R11", rdata & 32'h2000, 32'h2000);

    // R6: mixed random traffic
    cur_req = "R6";
    for (int k = 0; k < 400; k++) begin
      tx_done = N'($urandom) & N'($urandom);
      irq_en  = N'($urandom);
      is_tx   = N'($urandom) | N'($urandom);
      addr    = 2'($urandom);
      wr      = ($urandom % 4) == 0;
      wdata   = $urandom;
      tick();
    end
    tx_done = '0; wr = 1'b0; tick(3);

    finish_run();
  end

endmodule